// File: doc/BRIEF.md
# Triggered ADC Scan Sequencer

This block is the control sequencer for a successive-approximation converter. It sits idle until a hardware trigger arrives. It then runs a power-settling delay and converts a group of consecutive analog channels one after another. After the last channel of the group it wraps back to the first and keeps scanning until software stops it. Each finished conversion updates a result register and raises a one-cycle interrupt. The analog converter is outside the block. The sequencer talks to it through a start strobe, a channel number, a cancel strobe, a done strobe and a data word.

Software reaches the sequencer through three write strobes, each with its own data: the enable bit, the start/busy bit and the channel-group field. The current values of these three are returned on outputs. Several events abort the conversion in flight and restart the scan at the group's first channel: a retrigger, any write to the group field, or a write of 1 to the start bit while a conversion is in flight. An abort sends a one-cycle cancel to the converter. Clearing the start bit drops the block back to waiting for a trigger. Clearing the enable bit stops it completely.

The controller has five named states:
- `ST_STOP`: the block is disabled.
- `ST_STANDBY`: the block is waiting for a trigger.
- `ST_STABILIZE`: the settling delay is running.
- `ST_LAUNCH`: a start is being issued for one cycle.
- `ST_CONVERT`: the block is waiting for done.

The transitions are:
- **wake**: `ST_STOP` to `ST_STANDBY`.
- **arm**: `ST_STANDBY` to `ST_STABILIZE`.
- **settle**: `ST_STABILIZE` to `ST_LAUNCH`.
- **issue**: `ST_LAUNCH` to `ST_CONVERT`.
- **advance**: `ST_CONVERT` to `ST_LAUNCH`, taken on an accepted done.
- **restart**: from `ST_LAUNCH` or `ST_CONVERT` to `ST_LAUNCH`, with the channel index cleared.
- **quiesce**: any busy state to `ST_STANDBY`.
- **halt**: any state to `ST_STOP`.

Top module: `adc_scan_seq`

## Requirements
- R1: While `enabled` is 0, `busy` and `conv_start` stay 0 and `hw_trig` has no effect. Writing 1 through `cfg_we_enable`/`cfg_enable` moves the block to trigger standby with `busy` still 0. Out of reset, `enabled`, `busy`, `irq` and `result` are all 0.
- R2: A `hw_trig` pulse in standby sets `busy` at the next edge. The block then spends STAB_CYCLES cycles settling. The first `conv_start` appears STAB_CYCLES+1 cycles after the trigger cycle.
- R3: Channels are issued in the order group*SCAN_LEN+0, +1, … +SCAN_LEN-1. After the last one the scan wraps to +0 with no new trigger. Each `conv_start` lasts one cycle unless an abort restarts it.
- R4: A `conv_done` accepted while converting updates `result` with `conv_data` and pulses `irq` for one cycle, both at the next edge. The next channel's `conv_start` appears in that same cycle.
- R5: A `hw_trig` while launching or converting produces `conv_cancel` and a new `conv_start` on the group's first channel at the next edge. The aborted conversion produces no `irq`.
- R6: Any write to the group field while launching or converting aborts in the same way, even when the value is unchanged. The restarted scan uses the newly written group.
- R7: Writing 1 to the start bit while launching or converting aborts and restarts at the first channel. Writing 1 to it in standby or stop leaves `busy` at 0 and starts nothing.
- R8: Writing 0 to the start bit while busy clears `busy` at the next edge and returns the block to standby. If a conversion was in flight, `conv_cancel` pulses and no `irq` follows.
- R9: A `conv_done` that arrives outside the wait-for-done state changes neither `irq` nor `result`. This covers standby, settling and the launch cycle.
- R10: A register write takes priority over a `hw_trig` in the same cycle. A group write together with a trigger in standby arms the scan on the new group. A start-bit clear together with a trigger drops the trigger.
- R11: Writing 0 to the enable bit stops the block at the next edge (`enabled`=0, `busy`=0). If a conversion was in flight, `conv_cancel` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_enable | input | 1 | Write strobe for the enable bit |
| cfg_enable | input | 1 | Enable bit write data |
| cfg_we_start | input | 1 | Write strobe for the start/busy bit |
| cfg_start | input | 1 | Start bit write data |
| cfg_we_group | input | 1 | Write strobe for the channel-group field |
| cfg_group | input | GRP_W | Channel-group write data |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_start | output | 1 | Converter start strobe |
| conv_cancel | output | 1 | Converter abort strobe |
| conv_chan | output | CH_W | Channel being converted |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | DATA_W | Converter result word |
| result | output | DATA_W | Last accepted conversion result |
| irq | output | 1 | One-cycle end-of-conversion interrupt |
| enabled | output | 1 | Enable bit readback |
| busy | output | 1 | Start/busy bit readback |
| group | output | GRP_W | Channel-group readback |

## Verification
The hardest case to reach is a `conv_done` that arrives while the block is not waiting for one. With a well-behaved converter model this never happens, because the cancel clears the model before it can answer. The bench therefore injects extra done strobes of its own: in standby, during settling, and in the exact cycle that carries `conv_start`. It then checks that neither `irq` nor `result` moves. Aborts are timed relative to an observed `conv_start` so that each one lands in the wait-for-done state after part of a scan has finished. This shows the restart really returns to the first channel rather than continuing.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [2:0] {
        ST_STOP      = 3'd0,
        ST_STANDBY   = 3'd1,
        ST_STABILIZE = 3'd2,
        ST_LAUNCH    = 3'd3,
        ST_CONVERT   = 3'd4
    } scan_state_e;

    // Decoded control events, already resolved for priority
    typedef struct packed {
        logic wake;     // stop -> standby
        logic halt;     // enable cleared
        logic quiesce;  // start bit cleared
        logic restart;  // abort and return to first channel
        logic arm;      // trigger accepted in standby
    } scan_evt_t;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int GRP_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_enable,
    input  logic             enable_wdata,
    input  logic             we_start,
    input  logic             start_wdata,
    input  logic             we_group,
    input  logic [GRP_W-1:0] group_wdata,
    input  logic             hw_trig,
    input  scan_state_e      state,
    output logic             enable_q,
    output logic [GRP_W-1:0] group_q,
    output scan_evt_t        evt
);

    logic active;
    logic standby;
    logic abort_src;

    assign active  = (state == ST_LAUNCH) || (state == ST_CONVERT);
    assign standby = (state == ST_STANDBY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            group_q  <= '0;
        end else begin
            if (we_enable) enable_q <= enable_wdata;
            if (we_group)  group_q  <= group_wdata;
        end
    end

    // Register writes outrank the trigger: halt, then quiesce, then restart/arm
    assign abort_src = hw_trig || we_group || (we_start && start_wdata);

    always_comb begin
        evt         = '0;
        evt.wake    = we_enable && enable_wdata && !enable_q;
        evt.halt    = we_enable && !enable_wdata;
        evt.quiesce = we_start && !start_wdata && !evt.halt;
        evt.restart = active && abort_src && !evt.halt && !evt.quiesce;
        evt.arm     = standby && hw_trig && !evt.halt && !evt.quiesce;
    end

endmodule

// File: rtl/adc_scan_stab_timer.sv
module adc_scan_stab_timer #(
    parameter int STAB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int SCAN_LEN = 4,
    parameter int DATA_W   = 10,
    localparam int IDX_W   = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_evt_t         evt,
    input  logic              stab_expired,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output scan_state_e       state,
    output logic [IDX_W-1:0]  idx,
    output logic              conv_start,
    output logic              conv_cancel,
    output logic              irq,
    output logic [DATA_W-1:0] result,
    output logic              busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCAN_LEN - 1);

    scan_state_e state_q;
    scan_state_e state_d;
    logic        active;
    logic        abort;
    logic        accept;

    assign active = (state_q == ST_LAUNCH) || (state_q == ST_CONVERT);
    assign abort  = evt.halt || evt.quiesce || evt.restart;
    assign accept = (state_q == ST_CONVERT) && conv_done && !abort;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (evt.wake) state_d = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (evt.halt)     state_d = ST_STOP;
                else if (evt.arm) state_d = ST_STABILIZE;
            end
            ST_STABILIZE: begin
                if (evt.halt)         state_d = ST_STOP;
                else if (evt.quiesce) state_d = ST_STANDBY;
                else if (stab_expired) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (evt.halt)         state_d = ST_STOP;
                else if (evt.quiesce) state_d = ST_STANDBY;
                else if (evt.restart) state_d = ST_LAUNCH;
                else                  state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (evt.halt)         state_d = ST_STOP;
                else if (evt.quiesce) state_d = ST_STANDBY;
                else if (evt.restart) state_d = ST_LAUNCH;
                else if (conv_done)   state_d = ST_LAUNCH;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx         <= '0;
            conv_cancel <= 1'b0;
            irq         <= 1'b0;
            result      <= '0;
        end else begin
            conv_cancel <= active && abort;
            irq         <= accept;
            if (accept) result <= conv_data;
            if (evt.arm || evt.restart) begin
                idx <= '0;
            end else if (accept) begin
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            end
        end
    end

    assign state      = state_q;
    assign conv_start = (state_q == ST_LAUNCH);
    assign busy       = (state_q == ST_STABILIZE) || active;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int GROUPS      = 2,
    parameter int SCAN_LEN    = 4,
    parameter int DATA_W      = 10,
    parameter int STAB_CYCLES = 8,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int IDX_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1,
    localparam int CH_W  = ((GROUPS * SCAN_LEN) > 1) ? $clog2(GROUPS * SCAN_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_enable,
    input  logic              cfg_enable,
    input  logic              cfg_we_start,
    input  logic              cfg_start,
    input  logic              cfg_we_group,
    input  logic [GRP_W-1:0]  cfg_group,
    input  logic              hw_trig,
    output logic              conv_start,
    output logic              conv_cancel,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result,
    output logic              irq,
    output logic              enabled,
    output logic              busy,
    output logic [GRP_W-1:0]  group
);

    scan_state_e      fsm_state;
    scan_evt_t        evt;
    logic [IDX_W-1:0] idx;
    logic             stab_expired;

    adc_scan_regs #(.GRP_W(GRP_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_enable    (cfg_we_enable),
        .enable_wdata (cfg_enable),
        .we_start     (cfg_we_start),
        .start_wdata  (cfg_start),
        .we_group     (cfg_we_group),
        .group_wdata  (cfg_group),
        .hw_trig      (hw_trig),
        .state        (fsm_state),
        .enable_q     (enabled),
        .group_q      (group),
        .evt          (evt)
    );

    adc_scan_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (evt.arm),
        .run     (fsm_state == ST_STABILIZE),
        .expired (stab_expired)
    );

    adc_scan_fsm #(.SCAN_LEN(SCAN_LEN), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .stab_expired (stab_expired),
        .conv_done    (conv_done),
        .conv_data    (conv_data),
        .state        (fsm_state),
        .idx          (idx),
        .conv_start   (conv_start),
        .conv_cancel  (conv_cancel),
        .irq          (irq),
        .result       (result),
        .busy         (busy)
    );

    assign conv_chan = CH_W'(group * SCAN_LEN) + CH_W'(idx);

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_scan_pkg::*;
#(
    parameter int GRP_W    = 1,
    parameter int CH_W     = 3,
    parameter int SCAN_LEN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we_enable,
    input logic             cfg_enable,
    input logic             cfg_we_start,
    input logic             cfg_start,
    input logic             cfg_we_group,
    input logic [GRP_W-1:0] cfg_group,
    input logic             hw_trig,
    input logic             conv_start,
    input logic             conv_cancel,
    input logic [CH_W-1:0]  conv_chan,
    input logic             conv_done,
    input logic             irq,
    input logic             enabled,
    input logic             busy,
    input scan_state_e      fsm_state
);

    assert_stopped_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (!busy && !conv_start));

    assert_trig_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && hw_trig && !cfg_we_enable) |=> !busy);

    assert_arm_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STANDBY && hw_trig && !cfg_we_enable && !cfg_we_start)
        |=> (busy && !conv_start));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!conv_start || conv_cancel));

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_cancel_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_cancel |-> !irq);

    assert_group_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_CONVERT && cfg_we_group && !cfg_we_enable && !cfg_we_start)
        |=> (conv_start && conv_cancel && conv_chan == CH_W'($past(cfg_group) * SCAN_LEN)));

    assert_start_rewrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_CONVERT && cfg_we_start && cfg_start && !cfg_we_enable && !cfg_we_group)
        |=> (conv_start && conv_cancel));

    assert_quiesce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_start && !cfg_start && busy && !cfg_we_enable) |=> (!busy && enabled));

    assert_launch_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_start) |=> !irq);

    assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_enable && !cfg_enable) |=> (!enabled && !busy));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .GRP_W    (GRP_W),
    .CH_W     (CH_W),
    .SCAN_LEN (SCAN_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we_enable (cfg_we_enable),
    .cfg_enable    (cfg_enable),
    .cfg_we_start  (cfg_we_start),
    .cfg_start     (cfg_start),
    .cfg_we_group  (cfg_we_group),
    .cfg_group     (cfg_group),
    .hw_trig       (hw_trig),
    .conv_start    (conv_start),
    .conv_cancel   (conv_cancel),
    .conv_chan     (conv_chan),
    .conv_done     (conv_done),
    .irq           (irq),
    .enabled       (enabled),
    .busy          (busy),
    .fsm_state     (fsm_state)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

    localparam int GROUPS   = 2;
    localparam int SCAN_LEN = 4;
    localparam int DATA_W   = 10;
    localparam int STAB     = 8;
    localparam int LAT      = 5;
    localparam int GRP_W    = 1;
    localparam int CH_W     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we_en = 0, en_d = 0, we_st = 0, st_d = 0, we_gr = 0;
    logic [GRP_W-1:0] gr_d = '0;
    logic trig = 0;
    logic conv_start, conv_cancel, irq, enabled, busy;
    logic [CH_W-1:0] conv_chan;
    logic [DATA_W-1:0] result;
    logic [GRP_W-1:0] group;
    logic conv_done;
    logic [DATA_W-1:0] conv_data;

    logic cv_done = 0;
    logic inj_done = 0;
    int   cv_cnt = 0;
    int   cv_ch = 0;

    int checks = 0;
    int failures = 0;
    int irq_total = 0;
    logic [DATA_W-1:0] res_q[$];

    always #10 clk = ~clk;

    adc_scan_seq #(.GROUPS(GROUPS), .SCAN_LEN(SCAN_LEN), .DATA_W(DATA_W), .STAB_CYCLES(STAB)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_enable(we_en), .cfg_enable(en_d),
        .cfg_we_start(we_st), .cfg_start(st_d),
        .cfg_we_group(we_gr), .cfg_group(gr_d),
        .hw_trig(trig),
        .conv_start(conv_start), .conv_cancel(conv_cancel), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data),
        .result(result), .irq(irq), .enabled(enabled), .busy(busy), .group(group)
    );

    function automatic logic [DATA_W-1:0] fval(input int ch);
        return DATA_W'((ch * 71 + 13) % 1024);
    endfunction

    assign conv_done = cv_done | inj_done;
    assign conv_data = inj_done ? 10'h2AA : fval(cv_ch);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // converter responder: fixed latency, cleared by cancel
    always @(negedge clk) begin
        if (conv_cancel) cv_cnt = 0;
        if (conv_start) begin
            cv_cnt = LAT;
            cv_ch  = int'(conv_chan);
        end else if (cv_cnt > 0) begin
            cv_cnt = cv_cnt - 1;
        end
        cv_done = (cv_cnt == 1);
        if (irq) begin
            res_q.push_back(result);
            irq_total++;
        end
    end

    // reference model: 0 stop, 1 standby, 2 settle, 3 launch, 4 convert
    int m_st = 0, m_idx = 0, m_grp = 0, m_cnt = 0, m_res = 0;
    bit m_en = 0, m_irq = 0, m_can = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_grp = 0; m_cnt = 0; m_res = 0;
            m_en = 0; m_irq = 0; m_can = 0;
        end else begin
            bit conv;
            conv  = (m_st == 3) || (m_st == 4);
            m_irq = 0;
            m_can = 0;
            if (we_gr) m_grp = int'(gr_d);
            if (we_en && !en_d) begin
                m_can = conv; m_st = 0; m_en = 0;
            end else if (m_st == 0) begin
                if (we_en && en_d) begin m_en = 1; m_st = 1; end
            end else if (we_st && !st_d) begin
                m_can = conv; m_st = 1;
            end else if (m_st == 1) begin
                if (trig) begin m_st = 2; m_cnt = STAB - 1; m_idx = 0; end
            end else if (m_st == 2) begin
                if (m_cnt == 0) m_st = 3; else m_cnt--;
            end else if (conv && (trig || we_gr || (we_st && st_d))) begin
                m_can = 1; m_idx = 0; m_st = 3;
            end else if (m_st == 3) begin
                m_st = 4;
            end else if (m_st == 4 && conv_done) begin
                m_res = int'(conv_data); m_irq = 1;
                m_idx = (m_idx + 1) % SCAN_LEN; m_st = 3;
            end
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check(enabled == m_en, "R1 enabled", enabled, m_en);
            check(busy == (m_st >= 2), "R2 busy", busy, (m_st >= 2));
            check(conv_start == (m_st == 3), "R3 conv_start", conv_start, (m_st == 3));
            check(int'(conv_chan) == m_grp * SCAN_LEN + m_idx, "R3 conv_chan",
                  conv_chan, m_grp * SCAN_LEN + m_idx);
            check(conv_cancel == m_can, "R5 conv_cancel", conv_cancel, m_can);
            check(irq == m_irq, "R4 irq", irq, m_irq);
            check(int'(result) == m_res, "R4 result", result, m_res);
        end
    end

    task automatic drive(input bit a_we_en, input bit a_en, input bit a_we_st, input bit a_st,
                         input bit a_we_gr, input int a_gr, input bit a_trig);
        we_en = a_we_en; en_d = a_en; we_st = a_we_st; st_d = a_st;
        we_gr = a_we_gr; gr_d = GRP_W'(a_gr); trig = a_trig;
        @(negedge clk);
        we_en = 0; en_d = 0; we_st = 0; st_d = 0; we_gr = 0; trig = 0;
    endtask

    task automatic wait_start();
        while (!conv_start) @(negedge clk);
    endtask

    task automatic wait_irqs(input int n);
        while (res_q.size() < n) @(negedge clk);
    endtask

    task automatic inject();
        inj_done = 1;
        @(negedge clk);
        inj_done = 0;
    endtask

    task automatic finish_sim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        int n;
        int snap;
        logic [DATA_W-1:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!enabled && !busy && !irq && result == 0, "R1 reset", {enabled, busy, irq}, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        check(!busy, "R1 trigger while stopped", busy, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        check(enabled && !busy, "R1 enable to standby", {enabled, busy}, 2);

        // R2 settling latency
        drive(0, 0, 0, 0, 0, 0, 1);
        n = 1;
        while (!conv_start) begin @(negedge clk); n++; end
        check(n == STAB + 1, "R2 trigger to first start", n, STAB + 1);
        check(conv_chan == 0, "R3 first channel", conv_chan, 0);

        // R3/R4 sequence with wrap
        res_q.delete();
        wait_irqs(8);
        for (int i = 0; i < 8; i++)
            check(res_q[i] == fval(i % SCAN_LEN), "R3 R4 scan order", res_q[i], fval(i % SCAN_LEN));

        // R5 retrigger mid-scan
        res_q.delete();
        wait_irqs(2);
        wait_start(); @(negedge clk); @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 1);
        check(conv_cancel && conv_start && conv_chan == 0, "R5 retrigger restart",
              {conv_cancel, conv_start, conv_chan}, 3'b000 | 5'b11000);
        res_q.delete();
        wait_irqs(1);
        check(res_q[0] == fval(0), "R5 first result after restart", res_q[0], fval(0));

        // R6 group rewrite, same value then new group
        wait_start(); @(negedge clk);
        drive(0, 0, 0, 0, 1, 0, 0);
        check(conv_cancel && conv_start && conv_chan == 0, "R6 same-value rewrite", conv_chan, 0);
        wait_start(); @(negedge clk);
        drive(0, 0, 0, 0, 1, 1, 0);
        check(conv_start && conv_chan == SCAN_LEN, "R6 new group base", conv_chan, SCAN_LEN);
        res_q.delete();
        wait_irqs(4);
        for (int i = 0; i < 4; i++)
            check(res_q[i] == fval(SCAN_LEN + i), "R6 new group order", res_q[i], fval(SCAN_LEN + i));

        // R7 start rewrite while converting
        wait_start(); @(negedge clk); @(negedge clk);
        drive(0, 0, 1, 1, 0, 0, 0);
        check(conv_cancel && conv_start && conv_chan == SCAN_LEN, "R7 start rewrite restart",
              conv_chan, SCAN_LEN);

        // R8 start clear while converting
        wait_start(); @(negedge clk); @(negedge clk);
        drive(0, 0, 1, 0, 0, 0, 0);
        check(!busy && conv_cancel, "R8 quiesce", {busy, conv_cancel}, 1);
        snap = irq_total;
        repeat (LAT + 3) @(negedge clk);
        check(irq_total == snap && !busy, "R8 no irq after quiesce", irq_total, snap);

        // R7 start write in standby ignored
        drive(0, 0, 1, 1, 0, 0, 0);
        check(!busy, "R7 start write in standby", busy, 0);
        repeat (3) @(negedge clk);
        check(!busy && !conv_start, "R7 no software start", busy, 0);

        // R9 stray done in standby, settling, launch
        keep = result;
        inject();
        check(!irq && result == keep, "R9 done in standby", irq, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        inject();
        check(!irq && result == keep, "R9 done while settling", irq, 0);
        wait_start();
        inject();
        check(!irq && result == keep, "R9 done in launch cycle", irq, 0);

        // R10 priority cases
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 1);
        check(busy, "R10 group write with trigger arms", busy, 1);
        wait_start();
        check(conv_chan == 0, "R10 arm uses new group", conv_chan, 0);
        wait_start(); @(negedge clk);
        drive(0, 0, 1, 0, 0, 0, 1);
        check(!busy, "R10 clear beats trigger", busy, 0);

        // R11 disable during conversion
        drive(0, 0, 0, 0, 0, 0, 1);
        wait_start(); @(negedge clk); @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 0);
        check(!enabled && !busy && conv_cancel, "R11 halt", {enabled, busy, conv_cancel}, 1);
        drive(0, 0, 0, 0, 0, 0, 1);
        check(!busy, "R1 trigger after halt", busy, 0);

        repeat (5) @(negedge clk);
        finish_sim();
    end

endmodule